// File: doc/BRIEF.md
# Serial Bit Clock Baud Generator

This block derives a serial bit clock from the system clock for a synchronous serial port. Each direction (transmit and receive) has its own 16-bit clock-select word with the same layout. The word holds a 5-bit prescaler field and a 3-bit divider code. The overall division ratio is the prescaler value multiplied by a power-of-two ratio picked by the code. While a channel is enabled it produces two outputs. The first is a one-cycle tick at the divided rate. The second is a serial clock level that flips after every tick and rests at a programmable idle level when the channel is disabled.

The surrounding port holds the clock-select words and drives them in as plain inputs. The generator takes a copy of a channel's word only while that channel is disabled or in the cycle that ends a divided period. A setting changed mid-period therefore never cuts a period short or stretches it in a way that would give a runt clock pulse.

Top module: `baud_gen`

## Requirements
- R1: The prescaler value is the field in select bits 12:8 plus one, giving 1 to 32. A prescaler of 32 with code 4 divides by 1024.
- R2: Divider codes 0, 1, 2, 3 and 4 in select bits 2:0 give a second-stage ratio of 2, 4, 8, 16 and 32.
- R3: Divider code 7 bypasses the second stage, so the total ratio equals the prescaler value.
- R4: The reserved divider codes 5 and 6 behave exactly like code 7.
- R5: With the total ratio N, an enabled channel raises its tick for one cycle at the N-th cycle after enable and every N cycles after that. The tick is low whenever the channel is disabled.
- R6: An overall ratio of 1 (prescaler field 0 with a bypass code) holds the tick high on every enabled cycle.
- R7: A select word changed while the channel runs takes effect only after the next tick. The current period completes with the old ratio.
- R8: The serial clock equals the idle input while the channel is disabled and starts at the idle level on enable. It inverts in the cycle after every tick.
- R9: Transmit and receive channels are independent and decode their words identically. Select bits 15:13 and 7:3 have no effect.
- R10: After reset both ticks are low and both serial clocks sit at their idle levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_sel_i | input | 16 | Transmit clock-select word |
| tx_en_i | input | 1 | Transmit channel run |
| tx_idle_i | input | 1 | Transmit serial clock idle level |
| tx_tick_o | output | 1 | Transmit divided clock enable |
| tx_sck_o | output | 1 | Transmit serial clock |
| rx_sel_i | input | 16 | Receive clock-select word |
| rx_en_i | input | 1 | Receive channel run |
| rx_idle_i | input | 1 | Receive serial clock idle level |
| rx_tick_o | output | 1 | Receive divided clock enable |
| rx_sck_o | output | 1 | Receive serial clock |

## Verification
The hardest case to reach is a select word that changes in the middle of a divided period. The old ratio must still govern the rest of that period, and the new one must apply only from the following tick. The bench switches the word a few cycles into a long period while the channel runs. It compares every cycle against a period model that reloads its ratio only when it predicts a tick. The full 1024 ratio is also run through two whole periods so that both counters wrap at their widest setting.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;
  localparam int SEL_W   = 16;
  localparam int PRE_W   = 5;
  localparam int PRE_LSB = 8;
  localparam int CODE_W  = 3;
  localparam int CODE_MAX = 4;            // highest power-of-two code
  localparam int POW_W   = CODE_MAX + 1;  // stage-two counter width

  typedef struct packed {
    logic [PRE_W-1:0]  pre_m1;
    logic              bypass;
    logic [CODE_W-1:0] code;
  } baud_cfg_t;

  function automatic baud_cfg_t decode_sel(input logic [SEL_W-1:0] s);
    baud_cfg_t c;
    c.pre_m1 = s[PRE_LSB +: PRE_W];
    c.code   = s[CODE_W-1:0];
    c.bypass = (s[CODE_W-1:0] > CODE_W'(CODE_MAX));
    return c;
  endfunction
endpackage

// File: rtl/baud_prescale.sv
module baud_prescale #(
  parameter int PRE_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [PRE_W-1:0] limit_i,
  input  logic             clr_i,
  output logic             step_o
);
  logic [PRE_W-1:0] cnt_q;

  assign step_o = run_i && (cnt_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (!run_i || step_o || clr_i) cnt_q <= '0;
    else                             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/baud_pow2.sv
module baud_pow2 #(
  parameter int POW_W  = 5,
  parameter int CODE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              step_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              bypass_i,
  output logic              tick_o
);
  logic [POW_W-1:0] cnt_q;
  logic [POW_W-1:0] mask;
  logic             term;

  always_comb begin
    for (int i = 0; i < POW_W; i++) mask[i] = (i <= int'(code_i));
  end

  assign term   = (cnt_q == mask);
  assign tick_o = step_i && (bypass_i || term);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else if (step_i)          cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/baud_chan.sv
module baud_chan
  import baud_gen_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             en_i,
  input  logic             idle_i,
  output logic             tick_o,
  output logic             sck_o
);
  baud_cfg_t act_q;
  logic      step;
  logic      phase_q;

  // shadow copy: reload only when idle or at a period boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               act_q <= decode_sel('0);
    else if (!en_i || tick_o)  act_q <= decode_sel(sel_i);
  end

  baud_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (en_i),
    .limit_i (act_q.pre_m1),
    .clr_i   (tick_o),
    .step_o  (step)
  );

  baud_pow2 #(.POW_W(POW_W), .CODE_W(CODE_W)) u_pow (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (en_i),
    .step_i   (step),
    .code_i   (act_q.code),
    .bypass_i (act_q.bypass),
    .tick_o   (tick_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     phase_q <= 1'b0;
    else if (!en_i)  phase_q <= 1'b0;
    else if (tick_o) phase_q <= ~phase_q;
  end

  assign sck_o = idle_i ^ phase_q;
endmodule

// File: rtl/baud_gen.sv
module baud_gen
  import baud_gen_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] tx_sel_i,
  input  logic             tx_en_i,
  input  logic             tx_idle_i,
  output logic             tx_tick_o,
  output logic             tx_sck_o,
  input  logic [SEL_W-1:0] rx_sel_i,
  input  logic             rx_en_i,
  input  logic             rx_idle_i,
  output logic             rx_tick_o,
  output logic             rx_sck_o
);
  logic [NCH-1:0][SEL_W-1:0] sel;
  logic [NCH-1:0]            en, idle, tick, sck;

  assign sel  = {rx_sel_i, tx_sel_i};
  assign en   = {rx_en_i, tx_en_i};
  assign idle = {rx_idle_i, tx_idle_i};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    baud_chan u_ch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sel_i  (sel[g]),
      .en_i   (en[g]),
      .idle_i (idle[g]),
      .tick_o (tick[g]),
      .sck_o  (sck[g])
    );
  end

  assign tx_tick_o = tick[0];
  assign tx_sck_o  = sck[0];
  assign rx_tick_o = tick[1];
  assign rx_sck_o  = sck[1];
endmodule

// File: rtl/baud_gen_chk.sv
module baud_gen_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] tx_sel_i,
  input logic        tx_en_i,
  input logic        tx_idle_i,
  input logic        tx_tick_o,
  input logic        tx_sck_o,
  input logic [15:0] rx_sel_i,
  input logic        rx_en_i,
  input logic        rx_idle_i,
  input logic        rx_tick_o,
  input logic        rx_sck_o
);
  function automatic logic is_div1(input logic [15:0] s);
    return (s[12:8] == 5'd0) && (s[2:0] > 3'd4);
  endfunction

  assert_tick_needs_en_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_tick_o |-> tx_en_i) and (rx_tick_o |-> rx_en_i));

  assert_idle_level_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |=> (tx_sck_o == tx_idle_i));

  assert_rx_idle_level_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> (rx_sck_o == rx_idle_i));

  assert_sck_flips_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_tick_o |=> ((tx_sck_o ^ tx_idle_i) != $past(tx_sck_o ^ tx_idle_i)));

  assert_back_to_back_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_tick_o && $past(tx_tick_o)) |-> is_div1($past(tx_sel_i)));

  assert_div1_every_cycle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_i && $past(tx_tick_o) && is_div1($past(tx_sel_i))) |-> tx_tick_o);
endmodule

bind baud_gen baud_gen_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tx_sel_i  (tx_sel_i),
  .tx_en_i   (tx_en_i),
  .tx_idle_i (tx_idle_i),
  .tx_tick_o (tx_tick_o),
  .tx_sck_o  (tx_sck_o),
  .rx_sel_i  (rx_sel_i),
  .rx_en_i   (rx_en_i),
  .rx_idle_i (rx_idle_i),
  .rx_tick_o (rx_tick_o),
  .rx_sck_o  (rx_sck_o)
);

// File: tb/tb_baud_gen.sv
`timescale 1ns/1ps
module tb_baud_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] tx_sel_i = '0, rx_sel_i = '0;
  logic        tx_en_i = 1'b0, rx_en_i = 1'b0;
  logic        tx_idle_i = 1'b0, rx_idle_i = 1'b0;
  logic        tx_tick_o, tx_sck_o, rx_tick_o, rx_sck_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  baud_gen dut (.*);

  function automatic int ratio(input logic [15:0] s);
    int p = int'(s[12:8]) + 1;
    return (s[2:0] <= 3'd4) ? p * (2 << s[2:0]) : p;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // runs both channels against a period model; optional mid-run select switch
  task automatic run_pair(input logic [15:0] ts, input logic [15:0] rs, input int ncyc,
                          input int sw, input logic [15:0] ts2, input logic [15:0] rs2,
                          input bit idl, input string req);
    int tn, rn, tc = 0, rc = 0;
    bit tp = 0, rp = 0;
    int bad_tt = -1, bad_ts = -1, bad_rt = -1, bad_rs = -1;
    int a_tt = 0, e_tt = 0, a_rt = 0, e_rt = 0;
    @(negedge clk_i);
    tx_sel_i = ts; rx_sel_i = rs; tx_idle_i = idl; rx_idle_i = idl;
    tx_en_i = 0; rx_en_i = 0;
    @(negedge clk_i);
    tn = ratio(ts); rn = ratio(rs);
    tx_en_i = 1; rx_en_i = 1;
    for (int i = 0; i < ncyc; i++) begin
      bit et, er;
      if (i == sw) begin tx_sel_i = ts2; rx_sel_i = rs2; end
      #1;
      et = (tc == tn - 1); er = (rc == rn - 1);
      if (tx_tick_o !== et && bad_tt < 0) begin bad_tt = i; a_tt = tx_tick_o; e_tt = et; end
      if (rx_tick_o !== er && bad_rt < 0) begin bad_rt = i; a_rt = rx_tick_o; e_rt = er; end
      if (tx_sck_o !== (idl ^ tp) && bad_ts < 0) bad_ts = i;
      if (rx_sck_o !== (idl ^ rp) && bad_rs < 0) bad_rs = i;
      if (et) begin tc = 0; tn = ratio(tx_sel_i); tp = ~tp; end else tc++;
      if (er) begin rc = 0; rn = ratio(rx_sel_i); rp = ~rp; end else rc++;
      @(negedge clk_i);
    end
    tx_en_i = 0; rx_en_i = 0;
    chk(bad_tt < 0, {req, " tx tick"}, a_tt, e_tt);
    chk(bad_rt < 0, {req, " rx tick"}, a_rt, e_rt);
    chk(bad_ts < 0, {req, " tx sck"}, bad_ts, -1);
    chk(bad_rs < 0, {req, " rx sck"}, bad_rs, -1);
  endtask

  task automatic t_reset();  // R10
    #1;
    chk(tx_tick_o == 0 && rx_tick_o == 0, "R10 ticks", tx_tick_o + rx_tick_o, 0);
    chk(tx_sck_o == tx_idle_i && rx_sck_o == rx_idle_i, "R10 sck", tx_sck_o, tx_idle_i);
  endtask

  task automatic t_idle();  // R8 R5: disabled channel holds idle, no ticks
    int bad = 0;
    @(negedge clk_i);
    tx_en_i = 0; rx_en_i = 0; tx_idle_i = 1; rx_idle_i = 0; tx_sel_i = 16'h0007;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i); #1;
      if (tx_sck_o !== 1 || rx_sck_o !== 0 || tx_tick_o || rx_tick_o) bad++;
    end
    chk(bad == 0, "R8 idle hold", bad, 0);
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    t_reset();
    rst_ni = 1;
    run_pair(16'h0000, 16'h0001, 40, -1, 0, 0, 0, "R2 R5 div2/div4");
    run_pair(16'h0004, 16'h0203, 150, -1, 0, 0, 0, "R2 div32/div48");
    run_pair(16'h0407, 16'h0405, 30, 12, 16'h0407, 16'h0406, 0, "R3 R4 bypass");
    run_pair(16'h0007, 16'h0006, 20, -1, 0, 0, 1, "R6 div1");
    run_pair(16'h1F04, 16'h1F07, 2100, -1, 0, 0, 0, "R1 div1024/div32");
    run_pair(16'h0002, 16'h0303, 120, 3, 16'h0100, 16'h0001, 1, "R7 change mid-period");
    run_pair(16'h0007, 16'h0100, 30, 5, 16'h0002, 16'h0007, 0, "R7 div1 to div8");
    run_pair(16'hE2F9, 16'hA0FF, 60, -1, 0, 0, 0, "R9 ignored bits");
    t_idle();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk_i);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule